// File: doc/BRIEF.md
# Zero-Turnaround Burst SRAM Cycle Controller

This block models a synchronous static memory that accepts a new command on every rising clock edge, with no idle cycle when the bus changes direction between writes and reads. Each word has two byte lanes of nine bits. On every accepted edge the controller decodes three chip selects, a load/step control, a write strobe, per-lane write strobes and a hold input. From these it decides what the current cycle is: idle, read, dummy read, write, aborted write or sleep.

A burst begins when `step` is low and all three selects agree. Later cycles with `step` high walk a four-word group, either in wrap-around counting order or in XOR order. The read/write type of every continuation is the one captured at burst start. Write data for an address is taken one accepted edge after that address. Read data leaves the block in the cycle after its address edge. It is gated by an output enable that acts without the clock. A sleep input quiets the bus at once and takes two edges to enter and two edges to leave.

Top module: `sram_burst_ctl`

## Requirements
- R1: While reset is held and after it, the data bus is not driven (`rdata_oe` low), whatever `out_en_n` is.
- R2: An accepted edge with `step` low starts a burst only if `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other select pattern deselects, and the bus is not driven in the following cycle.
- R3: An accepted edge with `step` high while deselected leaves the block deselected, with the bus not driven.
- R4: Within a burst, the two low address bits on the k-th step are (start+k) mod 4 when `seq_mode`=0 and start XOR k when `seq_mode`=1. Upper address bits stay fixed, and the group wraps after four words. `seq_mode` is held constant through a burst.
- R5: `wr_n` is sampled only at burst start. On continue edges its level has no effect on the cycle type.
- R6: Write data on `wdata` is stored on the accepted edge that follows the write address edge. `lane_wr_n[0]` low writes bits 8:0 and `lane_wr_n[1]` low writes bits 17:9. Both high store nothing (write abort).
- R7: In every write or aborted-write cycle, the bus is not driven, even with `out_en_n` low.
- R8: In a read cycle, `rdata` shows the word at the current burst address, and `rdata_oe` follows `out_en_n` without waiting for a clock edge. With `out_en_n` high the cycle is a dummy read: the address still advances but the bus stays off.
- R9: A read started on the edge right after a write address edge may target that same address, and it returns the newly written word.
- R10: With `hold` high, the edge is ignored. Burst address, cycle type and any pending write data phase are kept for the next edge with `hold` low.
- R11: `sleep_req` high turns the bus off at once. The edge that first sees it and the next one complete entry. After `sleep_req` falls, two more edges pass before commands are accepted, and the block then comes back deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| step | input | 1 | 0 loads a new address, 1 continues the current burst |
| wr_n | input | 1 | Write strobe captured at burst start, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| hold | input | 1 | 1 ignores the clock edge |
| sleep_req | input | 1 | Sleep request, active high |
| out_en_n | input | 1 | Output enable, unclocked, active low |
| seq_mode | input | 1 | Burst order: 0 counting, 1 XOR |
| addr | input | ADDR_W | Word address loaded at burst start |
| wdata | input | LANES*LANE_W | Write data, one edge after the address |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | High when the block drives the data bus |

## Verification
The properties take for granted that `seq_mode` does not change inside a burst. They also assume that `out_en_n` and `sleep_req` change only between edges. The bench changes every input at the falling edge, and it alters `seq_mode` only together with a new load when no write data phase is pending. The asynchronous enable and sleep paths are probed away from edges, one nanosecond after the change. The stall and sleep checks never combine `hold` with a falling `sleep_req`.

// File: rtl/sram_ctl_pkg.sv
// Package: shared types for the burst SRAM controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sram_ctl_pkg;

    // Power sequencing states; RUN is the only state that accepts commands.
    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_DOZE  = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_WAKE  = 2'd3
    } pwr_state_t;

    // Classification of the cycle currently presented on the data bus.
    typedef enum logic [2:0] {
        CYC_IDLE  = 3'd0,
        CYC_READ  = 3'd1,
        CYC_DUMMY = 3'd2,
        CYC_WRITE = 3'd3,
        CYC_ABORT = 3'd4,
        CYC_SLEEP = 3'd5
    } cyc_kind_t;

    // Burst context captured when a burst starts.
    typedef struct packed {
        logic on;
        logic is_write;
    } burst_ctx_t;

endpackage

// File: rtl/sram_burst_seq.sv
// Module: burst address sequencer.
// Holds the upper address bits and the start offset of a burst, and counts
// the steps taken within it. Produces the current word address in either
// counting (wrap) order or XOR order.
// Assumes: seq_mode is constant for the whole burst; load has priority over advance.
module sram_burst_seq #(
    parameter int ADDR_W = 6,
    parameter int SEQ_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              seq_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HI_W = ADDR_W - SEQ_W;

    logic [HI_W-1:0]  base_hi;
    logic [SEQ_W-1:0] start_lo;
    logic [SEQ_W-1:0] step_cnt;
    logic [SEQ_W-1:0] lin_lo;
    logic [SEQ_W-1:0] xor_lo;
    logic [SEQ_W-1:0] cur_lo;

    // Capture base and offset on load, count steps on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi  <= '0;
            start_lo <= '0;
            step_cnt <= '0;
        end else if (load) begin
            base_hi  <= addr_in[ADDR_W-1:SEQ_W];
            start_lo <= addr_in[SEQ_W-1:0];
            step_cnt <= '0;
        end else if (advance) begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    // Counting order wraps naturally at the group width.
    always_comb lin_lo = start_lo + step_cnt;

    // XOR order, built bit by bit.
    for (genvar b = 0; b < SEQ_W; b++) begin : g_xor
        assign xor_lo[b] = start_lo[b] ^ step_cnt[b];
    end

    // Select the order requested by the mode input.
    always_comb cur_lo = seq_mode ? xor_lo : lin_lo;

    assign cur_addr = {base_hi, cur_lo};

endmodule

// File: rtl/sram_power_seq.sv
// Module: sleep entry and recovery sequencer.
// Entry takes two clock edges with sleep_req high. Recovery takes two clock
// edges with sleep_req low. Commands are accepted only in RUN with sleep_req low.
// Assumes: runs on every edge, independent of the hold input.
module sram_power_seq
    import sram_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic run_ok
);
    pwr_state_t state;
    pwr_state_t state_nxt;

    // Next-state selection for the sleep sequence.
    always_comb begin
        state_nxt = state;
        case (state)
            PWR_RUN:   if (sleep_req) state_nxt = PWR_DOZE;
            PWR_DOZE:  state_nxt = sleep_req ? PWR_SLEEP : PWR_WAKE;
            PWR_SLEEP: if (!sleep_req) state_nxt = PWR_WAKE;
            PWR_WAKE:  state_nxt = sleep_req ? PWR_DOZE : PWR_RUN;
            default:   state_nxt = PWR_RUN;
        endcase
    end

    // State register, reset into RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PWR_RUN;
        else        state <= state_nxt;
    end

    assign run_ok = (state == PWR_RUN) && !sleep_req;

endmodule

// File: rtl/sram_lane_array.sv
// Module: byte-lane storage array.
// One memory per lane, each with its own write enable. Read is combinational
// from the read address, so a word written on an edge is visible just after it.
// Assumes: contents are undefined until written; no reset on storage.
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane_en,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its enable is set.
        always_ff @(posedge clk) begin
            if (wr_lane_en[g]) mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/sram_burst_ctl.sv
// Module: zero-turnaround burst SRAM cycle controller (top).
// Decodes selects, load/step, write strobes, hold and sleep on each edge. It
// keeps the burst context and the pending write data phase, and drives the
// read bus through an unclocked output enable.
// Assumes: seq_mode is stable inside a burst; out_en_n may change at any time.
module sram_burst_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 9,
    parameter int SEQ_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    step,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    hold,
    input  logic                    sleep_req,
    input  logic                    out_en_n,
    input  logic                    seq_mode,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic              run_ok;
    logic              accept;
    logic              selected;
    logic              load_now;
    logic              adv_now;
    logic              wr_cycle_now;
    burst_ctx_t        ctx;
    logic [LANES-1:0]  pend_mask;
    logic [LANES-1:0]  commit_en;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rd_word;
    cyc_kind_t         cyc_kind;

    sram_power_seq u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .run_ok    (run_ok)
    );

    // Edge qualification and command decode.
    always_comb begin
        accept       = run_ok && !hold;
        selected     = !sel_a_n && sel_b && !sel_c_n;
        load_now     = accept && !step && selected;
        adv_now      = accept && step && ctx.on;
        wr_cycle_now = (load_now && !wr_n) || (adv_now && ctx.is_write);
    end

    sram_burst_seq #(
        .ADDR_W (ADDR_W),
        .SEQ_W  (SEQ_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_now),
        .advance  (adv_now),
        .seq_mode (seq_mode),
        .addr_in  (addr),
        .cur_addr (cur_addr)
    );

    // Burst context: cleared by sleep, set or cleared by a load, kept otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx <= '0;
        end else if (!run_ok) begin
            ctx <= '0;
        end else if (!hold && !step) begin
            ctx.on       <= selected;
            ctx.is_write <= selected && !wr_n;
        end
    end

    // Lane mask of the write whose data phase falls on the next accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mask <= '0;
        end else if (!run_ok) begin
            pend_mask <= '0;
        end else if (!hold) begin
            pend_mask <= wr_cycle_now ? ~lane_wr_n : '0;
        end
    end

    // The data phase completes on any edge that is not held.
    always_comb commit_en = hold ? '0 : pend_mask;

    sram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_mem (
        .clk        (clk),
        .wr_addr    (cur_addr),
        .wr_lane_en (commit_en),
        .wr_data    (wdata),
        .rd_addr    (cur_addr),
        .rd_data    (rd_word)
    );

    // Classify the cycle now on the bus.
    always_comb begin
        if (!run_ok)           cyc_kind = CYC_SLEEP;
        else if (!ctx.on)      cyc_kind = CYC_IDLE;
        else if (ctx.is_write) cyc_kind = (pend_mask == '0) ? CYC_ABORT : CYC_WRITE;
        else if (out_en_n)     cyc_kind = CYC_DUMMY;
        else                   cyc_kind = CYC_READ;
    end

    // Only a true read drives the bus.
    always_comb begin
        rdata_oe = (cyc_kind == CYC_READ);
        rdata    = rdata_oe ? rd_word : '0;
    end

endmodule

// File: rtl/sram_burst_ctl_chk.sv
// Module: property checker bound to sram_burst_ctl.
// Assumes: inputs change away from the rising edge.
module sram_burst_ctl_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              step,
    input logic              wr_n,
    input logic              hold,
    input logic              sleep_req,
    input logic              out_en_n,
    input logic              rdata_oe,
    input logic [ADDR_W-1:0] cur_addr
);
    logic sel_ok;
    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    // Bus quiet while reset is held.
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_quiet_r1: assert (!rdata_oe);
        end
    end

    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !step && !sel_ok) |=> !rdata_oe);

    p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !step && sel_ok && !wr_n) |=> !rdata_oe);

    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);

    p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(cur_addr));

    p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> !rdata_oe);

endmodule

bind sram_burst_ctl sram_burst_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .step      (step),
    .wr_n      (wr_n),
    .hold      (hold),
    .sleep_req (sleep_req),
    .out_en_n  (out_en_n),
    .rdata_oe  (rdata_oe),
    .cur_addr  (cur_addr)
);

// File: tb/tb_sram_burst_ctl.sv
module tb_sram_burst_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic        step = 1'b0, wr_n = 1'b1, hold = 1'b0, sleep_req = 1'b0;
    logic        out_en_n = 1'b0, seq_mode = 1'b0;
    logic [1:0]  lane_wr_n = 2'b11;
    logic [5:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic        rdata_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sram_burst_ctl dut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .step(step), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .hold(hold),
        .sleep_req(sleep_req), .out_en_n(out_en_n), .seq_mode(seq_mode),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    localparam logic [17:0] D4 = 18'h01234, D5 = 18'h02B5A, D6 = 18'h1C0C3;
    localparam logic [17:0] D7 = 18'h3A5A5, E6 = 18'h2F00F, E7 = 18'h15555;
    localparam logic [17:0] F8 = 18'h0BEEF, M6 = 18'h2F0C3;
    localparam logic [17:0] W0 = 18'h11111, W1 = 18'h22222, W2 = 18'h03333;
    localparam logic [17:0] W3 = 18'h14444, G20 = 18'h0ACE5;

    typedef struct packed {
        logic        sa_n;
        logic        sb;
        logic        sc_n;
        logic        st;
        logic        wn;
        logic [1:0]  bw;
        logic        oe_n;
        logic [5:0]  a;
        logic [17:0] d;
        logic        e_oe;
        logic [17:0] e_d;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h00,18'h0,1'b0,18'h0,4'd2}, // R2 sel_a_n high
        '{1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,6'h04,18'h0,1'b0,18'h0,4'd7}, // R7 write start
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,6'h00,D4,1'b0,18'h0,4'd6},    // R6 data for 4
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b00,1'b0,6'h00,D5,1'b0,18'h0,4'd5},    // R5 wr_n high ignored
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,6'h00,D6,1'b0,18'h0,4'd6},    // R6 data for 6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,2'b01,1'b0,6'h06,D7,1'b0,18'h0,4'd6},    // R6 upper-lane write at 6
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b11,1'b0,6'h00,E6,1'b0,18'h0,4'd6},    // R6 abort at 7
        '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h04,E7,1'b1,D4,4'd8},       // R8 read 4
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b11,1'b0,6'h00,18'h0,1'b1,D5,4'd5},    // R5 wr_n low ignored
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,6'h00,18'h0,1'b0,18'h0,4'd8}, // R8 dummy read 6
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,1'b1,D7,4'd6},    // R6 abort kept D7
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,1'b1,D4,4'd4},    // R4 wrap to 4
        '{1'b0,1'b0,1'b0,1'b0,1'b1,2'b11,1'b0,6'h04,18'h0,1'b0,18'h0,4'd2}, // R2 sel_b low
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,1'b0,18'h0,4'd3}, // R3 stay deselected
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,1'b0,6'h04,18'h0,1'b0,18'h0,4'd2}, // R2 sel_c_n high
        '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0,6'h00,18'h0,1'b0,18'h0,4'd3}, // R3 stay deselected
        '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h06,18'h0,1'b1,M6,4'd6},    // R6 merged lanes at 6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,6'h08,18'h0,1'b0,18'h0,4'd7}, // R7 write with oe low
        '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0,6'h08,F8,1'b1,F8,4'd9}        // R9 read after write
    };

    task automatic chk(input string tag, input logic eo, input logic [17:0] ed);
        n_chk++;
        if (rdata_oe !== eo || (eo && rdata !== ed)) begin
            n_bad++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", tag, rdata_oe, rdata, eo, ed);
        end
    endtask

    task automatic cyc(input logic sa_n, input logic sb, input logic sc_n, input logic st,
                       input logic wn, input logic [1:0] bw, input logic oe_n,
                       input logic [5:0] a, input logic [17:0] d);
        @(negedge clk);
        sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n; step = st; wr_n = wn;
        lane_wr_n = bw; out_en_n = oe_n; addr = a; wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: oe=%b data=%h expected oe=x data=x", rdata_oe, rdata);
        finish_up();
    end

    initial begin
        // R1: reset held with a read command and output enable low
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        chk("R1 during reset", 1'b0, 18'h0);
        @(negedge clk);
        rst_n = 1'b1;
        sel_b = 1'b0;
        #1;
        chk("R1 after reset", 1'b0, 18'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].sa_n, VECS[i].sb, VECS[i].sc_n, VECS[i].st, VECS[i].wn,
                VECS[i].bw, VECS[i].oe_n, VECS[i].a, VECS[i].d);
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].e_oe, VECS[i].e_d);
        end

        // R8: output enable acts between edges
        @(negedge clk);
        out_en_n = 1'b1;
        #1;
        chk("R8 oe off mid-cycle", 1'b0, 18'h0);
        out_en_n = 1'b0;
        #1;
        chk("R8 oe on mid-cycle", 1'b1, F8);

        // R4: XOR order write from 0x11 -> 11,10,13,12
        @(negedge clk);
        seq_mode = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 6'h11, 18'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'h00, W0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'h00, W1);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'h00, W2);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h10, W3);
        chk("R4 xor word 0x10", 1'b1, W1);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        chk("R4 xor word 0x11", 1'b1, W0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        chk("R4 xor word 0x12", 1'b1, W3);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        chk("R4 xor word 0x13", 1'b1, W2);

        // R4: counting order from 0x11 -> 11,12,13,10
        @(negedge clk);
        seq_mode = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h11, 18'h0);
        chk("R4 count word 0x11", 1'b1, W0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        chk("R4 count word 0x12", 1'b1, W3);

        // R10: held edge keeps the burst address
        @(negedge clk);
        hold = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 held read", 1'b1, W3);
        @(negedge clk);
        hold = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 resumed read 0x13", 1'b1, W2);

        // R10: held edge delays the write data phase
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 6'h20, 18'h0);
        @(negedge clk);
        hold = 1'b1;
        wdata = 18'h3FFFF;
        @(posedge clk);
        @(negedge clk);
        hold = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h00, G20);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h20, 18'h0);
        chk("R10 write data after hold", 1'b1, G20);

        // R11: sleep entry, hold and recovery
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h13, 18'h0);
        chk("R11 read before sleep", 1'b1, W2);
        @(negedge clk);
        sleep_req = 1'b1;
        #1;
        chk("R11 bus off at sleep request", 1'b0, 18'h0);
        repeat (3) @(posedge clk);
        #1;
        chk("R11 bus off while asleep", 1'b0, 18'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h13, 18'h0);
        @(negedge clk);
        sleep_req = 1'b0;
        @(posedge clk);
        #1;
        chk("R11 first recovery edge ignored", 1'b0, 18'h0);
        @(posedge clk);
        #1;
        chk("R11 second recovery edge ignored", 1'b0, 18'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'h00, 18'h0);
        chk("R11 deselected after wake", 1'b0, 18'h0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6'h13, 18'h0);
        chk("R11 read accepted after wake", 1'b1, W2);

        finish_up();
    end
endmodule